// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one read or write request into the column address stream of a synchronous DRAM burst. A start strobe captures a start column, a burst-length code and an ordering bit. From the next cycle on, the block presents one column per clock, with a valid flag, until the burst has run its length. A full-page burst runs with no end of its own. A terminate strobe cuts any burst short. The last-beat flag marks the final column of a fixed-length burst, so that auto-precharge logic downstream can close the row at the right time.

A start may arrive on any cycle, including inside a running burst. In that case the old burst is dropped and the new one begins at once. The column space is 256 entries (8 bits). Fixed bursts wrap inside their own aligned block of columns. A full-page burst wraps around the whole row.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held and on the first cycle after it is released, `col_valid_o` and `last_beat_o` are 0.
- R2: A start sampled high at a clock edge makes `col_valid_o` 1 after that edge, with `col_o` equal to the sampled start column. A start during a running burst abandons the old burst.
- R3: Length codes on `len_code_i` select the length: 3'b000 gives 1, 3'b001 gives 2, 3'b010 gives 4, 3'b011 gives 8 and 3'b111 gives full page. The codes 3'b100, 3'b101 and 3'b110 give length 1.
- R4: With `interleave_i`=0 and fixed length N, beat k shows column (S & ~(N-1)) | ((S+k) & (N-1)), where S is the start column.
- R5: With `interleave_i`=1 and fixed length N, beat k shows column S ^ k, where k < N.
- R6: A fixed burst of length N keeps `col_valid_o` high for exactly N cycles. `last_beat_o` is 1 only on beat N-1, and `col_valid_o` falls on the next cycle unless a new start was sampled.
- R7: A full-page burst shows (S+k) mod 256 on beat k whatever the ordering bit is. It continues past 256 beats and never raises `last_beat_o`.
- R8: A terminate sampled high during a burst, with no start in the same cycle, makes `col_valid_o` and `last_beat_o` 0 after that edge.
- R9: When start and terminate are sampled high in the same cycle, the start wins and a new burst begins.
- R10: A terminate sampled while idle has no effect: `col_valid_o` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Begin a new burst from `col_start_i` |
| col_start_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst-length code, see R3 |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| term_i | input | 1 | Stop the running burst |
| col_o | output | 8 | Column of the current beat |
| col_valid_o | output | 1 | A beat is presented this cycle |
| last_beat_o | output | 1 | Final beat of a fixed-length burst |

## Verification
Two events can fall in the same cycle. The first is a new start together with a terminate. The second is a new start on the last beat of a burst, or in the middle of one. The bench provokes both on purpose: it raises start and terminate in the same cycle, both while idle and in mid-burst, and it restarts a burst two beats in with a different length and ordering. In each case the start must win. The bench judges this by checking that the following cycles carry the new burst's full column sequence, worked out arithmetically, and that no beat of the abandoned burst appears.

// File: rtl/burst_col_pkg.sv
// Package: shared types for the burst column generator.
// Assumes: 3-bit burst-length code, unlisted codes mean a single beat.
package burst_col_pkg;
    localparam int LEN_CODE_W = 3;

    typedef enum logic [LEN_CODE_W-1:0] {
        BL_1    = 3'b000,
        BL_2    = 3'b001,
        BL_4    = 3'b010,
        BL_8    = 3'b011,
        BL_PAGE = 3'b111
    } burst_len_e;
endpackage

// File: rtl/burst_len_decode.sv
// Module: burst_len_decode
// Turns a burst-length code into a wrap mask (length-1) and a full-page flag.
// Assumes COL_W >= 3. Unlisted codes decode to a single beat.
module burst_len_decode
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [LEN_CODE_W-1:0] len_code_i,
    output logic [COL_W-1:0]      wrap_mask_o,
    output logic                  full_page_o
);
    // Purpose: map each code to its mask; full page wraps over the whole row.
    always_comb begin
        full_page_o = 1'b0;
        case (len_code_i)
            BL_2:    wrap_mask_o = COL_W'(1);
            BL_4:    wrap_mask_o = COL_W'(3);
            BL_8:    wrap_mask_o = COL_W'(7);
            BL_PAGE: begin
                wrap_mask_o = '1;
                full_page_o = 1'b1;
            end
            default: wrap_mask_o = '0;
        endcase
    end
endmodule

// File: rtl/burst_col_map.sv
// Module: burst_col_map
// Combines base column, beat index and wrap mask into the current column.
// Masked bits take either the incremented or the XORed value; others keep base.
// Assumes the caller clears the interleave bit for full-page bursts.
module burst_col_map #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base_col_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [COL_W-1:0] wrap_mask_i,
    input  logic             interleave_i,
    output logic [COL_W-1:0] col_o
);
    logic [COL_W-1:0] seq_sum;

    // Purpose: linear offset of the beat from the base column.
    always_comb seq_sum = base_col_i + beat_i;

    for (genvar b = 0; b < COL_W; b++) begin : g_bit
        // Purpose: pick the wrapped or the fixed value for one column bit.
        always_comb begin
            if (!wrap_mask_i[b])
                col_o[b] = base_col_i[b];
            else if (interleave_i)
                col_o[b] = base_col_i[b] ^ beat_i[b];
            else
                col_o[b] = seq_sum[b];
        end
    end
endmodule

// File: rtl/burst_beat_ctrl.sv
// Module: burst_beat_ctrl
// Holds the burst state: active flag, beat counter and the captured
// start column, mask and ordering. Start beats terminate, terminate beats
// natural end. Assumes synchronous active-low reset.
module burst_beat_ctrl #(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             term_i,
    input  logic [COL_W-1:0] col_start_i,
    input  logic [COL_W-1:0] wrap_mask_i,
    input  logic             full_page_i,
    input  logic             interleave_i,
    output logic             active_o,
    output logic             last_o,
    output logic [COL_W-1:0] beat_o,
    output logic [COL_W-1:0] base_col_o,
    output logic [COL_W-1:0] wrap_mask_o,
    output logic             interleave_o
);
    logic active_q;
    logic full_q;
    logic [COL_W-1:0] beat_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] mask_q;
    logic il_q;
    logic at_end;

    // Purpose: a fixed burst has reached its final beat.
    always_comb at_end = !full_q && (beat_q == mask_q);

    // Purpose: advance, restart or stop the burst each cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            full_q   <= 1'b0;
            beat_q   <= '0;
            base_q   <= '0;
            mask_q   <= '0;
            il_q     <= 1'b0;
        end else if (start_i) begin
            active_q <= 1'b1;
            full_q   <= full_page_i;
            beat_q   <= '0;
            base_q   <= col_start_i;
            mask_q   <= wrap_mask_i;
            il_q     <= interleave_i && !full_page_i;
        end else if (active_q) begin
            if (term_i || at_end)
                active_q <= 1'b0;
            beat_q <= beat_q + 1'b1;
        end
    end

    // Purpose: drive the state out to the mapper and the top.
    always_comb begin
        active_o     = active_q;
        last_o       = active_q && at_end;
        beat_o       = beat_q;
        base_col_o   = base_q;
        wrap_mask_o  = mask_q;
        interleave_o = il_q;
    end

    // R7: a full-page burst steps its beat by one every undisturbed cycle.
    assert_page_steps_R7: assert property (@(posedge clk) disable iff (!rst_n)
        active_q && full_q && !start_i && !term_i
        |=> active_q && beat_q == COL_W'($past(beat_q) + 1'b1));

    // R9: start together with terminate still leaves a burst running.
    assert_start_beats_term_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && term_i |=> active_q && beat_q == '0);
endmodule

// File: rtl/burst_col_gen.sv
// Module: burst_col_gen (top)
// Column address sequencer for one SDRAM burst: decodes the length code,
// keeps the beat state and maps each beat to a column.
// Assumes 256 columns by default; inputs are sampled on the rising edge.
module burst_col_gen
    import burst_col_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      col_start_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  interleave_i,
    input  logic                  term_i,
    output logic [COL_W-1:0]      col_o,
    output logic                  col_valid_o,
    output logic                  last_beat_o
);
    logic [COL_W-1:0] dec_mask;
    logic             dec_full;
    logic [COL_W-1:0] st_beat;
    logic [COL_W-1:0] st_base;
    logic [COL_W-1:0] st_mask;
    logic             st_il;

    burst_len_decode #(.COL_W(COL_W)) u_decode (
        .len_code_i  (len_code_i),
        .wrap_mask_o (dec_mask),
        .full_page_o (dec_full)
    );

    burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .term_i       (term_i),
        .col_start_i  (col_start_i),
        .wrap_mask_i  (dec_mask),
        .full_page_i  (dec_full),
        .interleave_i (interleave_i),
        .active_o     (col_valid_o),
        .last_o       (last_beat_o),
        .beat_o       (st_beat),
        .base_col_o   (st_base),
        .wrap_mask_o  (st_mask),
        .interleave_o (st_il)
    );

    burst_col_map #(.COL_W(COL_W)) u_map (
        .base_col_i   (st_base),
        .beat_i       (st_beat),
        .wrap_mask_i  (st_mask),
        .interleave_i (st_il),
        .col_o        (col_o)
    );

    // R2: the first beat after a start shows the sampled start column.
    assert_start_loads_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> col_valid_o && col_o == $past(col_start_i));

    // R6: a last beat is a valid beat and is followed by idle unless restarted.
    assert_last_is_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat_o |-> col_valid_o);
    assert_last_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        last_beat_o && !start_i |=> !col_valid_o);

    // R8: terminate without start ends the burst on the next cycle.
    assert_term_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        col_valid_o && term_i && !start_i |=> !col_valid_o && !last_beat_o);

    // R10: while idle, only a start can raise the valid flag.
    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !col_valid_o && !start_i |=> !col_valid_o);
endmodule

// File: tb/test_burst_col_gen.sv
`timescale 1ns/1ps
module test_burst_col_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [7:0] col_start_i = '0;
    logic [2:0] len_code_i = '0;
    logic       interleave_i = 1'b0;
    logic       term_i = 1'b0;
    logic [7:0] col_o;
    logic       col_valid_o;
    logic       last_beat_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_col_gen i_burst_col_gen (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .col_start_i(col_start_i),
        .len_code_i(len_code_i), .interleave_i(interleave_i), .term_i(term_i),
        .col_o(col_o), .col_valid_o(col_valid_o), .last_beat_o(last_beat_o)
    );

    // Burst length from code (R3); 0 stands for full page.
    function automatic int len_of(int code);
        case (code)
            0: return 1;
            1: return 2;
            2: return 4;
            3: return 8;
            7: return 0;
            default: return 1;
        endcase
    endfunction

    // Expected column of beat k (R4, R5, R7).
    function automatic logic [7:0] exp_col(int s, int code, int il, int k);
        int n = len_of(code);
        int m;
        if (n == 0) return 8'((s + k) % 256);
        m = n - 1;
        if (il != 0) return 8'(s ^ (k & m));
        return 8'((s & ~m) | ((s + k) & m));
    endfunction

    task automatic chk(string req, logic ev, logic el, logic [7:0] ec);
        n_cmp++;
        if (col_valid_o !== ev || last_beat_o !== el || (ev && col_o !== ec)) begin
            n_bad++;
            $display("FAIL %s: got valid=%0b last=%0b col=%0d, expected valid=%0b last=%0b col=%0d",
                     req, col_valid_o, last_beat_o, col_o, ev, el, ec);
        end
    endtask

    // Runs one burst; term_at >= 0 terminates on that beat (needed for full page).
    task automatic burst(int s, int code, int il, int term_at, string req);
        int n = len_of(code);
        int beats = (term_at >= 0) ? term_at + 1 : n;
        @(negedge clk);
        start_i = 1'b1; col_start_i = 8'(s); len_code_i = 3'(code);
        interleave_i = il[0]; term_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < beats; k++) begin
            chk(req, 1'b1, (n != 0 && k == n - 1), exp_col(s, code, il, k));
            if (k == term_at) term_i = 1'b1;
            @(negedge clk);
            term_i = 1'b0;
        end
        chk({req, " end"}, 1'b0, 1'b0, 8'd0);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got no finish, expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 in reset", 1'b0, 1'b0, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 1'b0, 1'b0, 8'd0);

        // R3 R4 R5 R6: every fixed code, both orders, every start column
        for (int code = 0; code < 7; code++)
            for (int il = 0; il < 2; il++)
                for (int s = 0; s < 256; s++)
                    burst(s, code, il, -1, "R3/R4/R5/R6 fixed sweep");

        // R7: full page wraps past 256 beats, ordering ignored
        for (int il = 0; il < 2; il++) begin
            burst(0, 7, il, 300, "R7 page");
            burst(1, 7, il, 260, "R7 page");
            burst(200, 7, il, 70, "R7 page");
            burst(255, 7, il, 257, "R7 page");
        end

        // R8: early terminate of fixed bursts
        burst(13, 3, 0, 2, "R8 term seq");
        burst(13, 3, 1, 5, "R8 term il");
        burst(6, 2, 0, 0, "R8 term first beat");

        // R10: terminate while idle
        @(negedge clk);
        term_i = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk("R10 idle term", 1'b0, 1'b0, 8'd0);
        end
        term_i = 1'b0;

        // R2: restart two beats into an 8-beat burst with a new length/order
        @(negedge clk);
        start_i = 1'b1; col_start_i = 8'd40; len_code_i = 3'd3; interleave_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 first beat", 1'b1, 1'b0, 8'd40);
        @(negedge clk);
        chk("R2 second beat", 1'b1, 1'b0, 8'd41);
        start_i = 1'b1; col_start_i = 8'd99; len_code_i = 3'd2; interleave_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            chk("R2 restart", 1'b1, (k == 3), exp_col(99, 2, 1, k));
            @(negedge clk);
        end
        chk("R2 restart end", 1'b0, 1'b0, 8'd0);

        // R2 R6: start on the last beat chains a new burst with no gap
        start_i = 1'b1; col_start_i = 8'd9; len_code_i = 3'd1; interleave_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R6 chain a0", 1'b1, 1'b0, 8'd9);
        @(negedge clk);
        chk("R6 chain a1", 1'b1, 1'b1, 8'd8);
        start_i = 1'b1; col_start_i = 8'd130; len_code_i = 3'd0;
        @(negedge clk);
        start_i = 1'b0;
        chk("R6 chain b0", 1'b1, 1'b1, 8'd130);
        @(negedge clk);
        chk("R6 chain end", 1'b0, 1'b0, 8'd0);

        // R9: start and terminate together, from idle and mid-burst
        start_i = 1'b1; term_i = 1'b1; col_start_i = 8'd5; len_code_i = 3'd2;
        interleave_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0;
        chk("R9 idle start+term", 1'b1, 1'b0, 8'd5);
        @(negedge clk);
        chk("R9 beat1", 1'b1, 1'b0, 8'd6);
        start_i = 1'b1; term_i = 1'b1; col_start_i = 8'd77; len_code_i = 3'd5;
        @(negedge clk);
        start_i = 1'b0; term_i = 1'b0;
        chk("R9 mid start+term, R3 code 5", 1'b1, 1'b1, 8'd77);
        @(negedge clk);
        chk("R9 end", 1'b0, 1'b0, 8'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule